// File: doc/BRIEF.md
# Two-Key Register Write-Protect Gate

This block stands on a simple 32-bit register write bus, in front of a peripheral register file, and guards that file against stray writes. Out of reset the file is locked. While it is locked, write strobes aimed at ordinary register addresses are dropped before they reach the file. To open the file, software writes a first 32-bit key to one kick address and then a second 32-bit key to another kick address. Once the file is open, writes pass through in the same cycle they arrive.

Writing any value other than the first key to the first kick address closes the file again. Writing zero there is the usual way to do it. A wrong second key, a second key written before the first, or any unrelated write between the two keys also leaves the file locked.

Read strobes are never held back. The kick addresses are handled inside the gate and are never passed on to the file. A single demonstration register at offset 0x00 stands in for the protected file.

Top module: `kick_wp_gate`

## Requirements
- R1: After reset, `locked` is 1, `key_pending` is 0 and `demo_q` is 0.
- R2: A write of 0x83E70B13 to address 0x6C, followed by a write of 0x95A4F1E0 to address 0x70, drives `locked` to 0 from the clock edge that takes the second write. That same edge also clears `key_pending`.
- R3: While `locked` is 1, a write to any non-kick address leaves `fwd_wr_en` at 0 and leaves `demo_q` unchanged.
- R4: A write of 0x83E70B13 to address 0x6C sets `key_pending`. Any later write other than 0x95A4F1E0 to 0x70 clears it, including a write to an ordinary address. After such a write, a following second key does not unlock.
- R5: Every write to 0x6C sets `locked` to 1. This holds for zero, for any other wrong value, and for the correct first key, which also sets `key_pending`.
- R6: A wrong value written to 0x70 sets `locked` to 1 and clears `key_pending`. So does the second key written while no first key is pending.
- R7: Writes to 0x6C and 0x70 never assert `fwd_wr_en`, whether the gate is locked or not.
- R8: While `locked` is 0, a write to a non-kick address asserts `fwd_wr_en` in the same cycle. A write to address 0x00 then loads `demo_q` with the write data at that clock edge.
- R9: `fwd_rd_en` equals `rd_en` in the same cycle, whether the gate is locked or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the bus |
| rd_en | input | 1 | Read strobe from the bus |
| addr | input | ADDR_W (8) | Byte address of the access |
| wdata | input | 32 | Write data |
| fwd_wr_en | output | 1 | Qualified write strobe to the register file |
| fwd_rd_en | output | 1 | Read strobe to the register file, never blocked |
| fwd_addr | output | ADDR_W (8) | Address passed through to the register file |
| fwd_wdata | output | 32 | Write data passed through to the register file |
| locked | output | 1 | 1 while protected writes are blocked |
| key_pending | output | 1 | 1 after a correct first key, until the next write |
| demo_q | output | 32 | Demonstration protected register at offset 0x00 |

## Verification
The forwarded write and read strobes are combinational, so they are due in the same cycle as the request. The bench samples them 1 ns after driving the inputs at the falling edge. The lock state, the pending flag and the demonstration register change at the rising edge that takes a write. The bench therefore reads them at the next falling edge, after the strobe has been removed. Each scenario task follows this one-edge rhythm, so every check is tied to the single register stage between the request and the result.

// File: rtl/kick_wp_gate.sv
module kick_wp_gate #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter logic [7:0]  KICK0_OFS = 8'h6C,
  parameter logic [7:0]  KICK1_OFS = 8'h70,
  parameter logic [7:0]  DEMO_OFS  = 8'h00,
  parameter logic [31:0] KEY0      = 32'h83E7_0B13,
  parameter logic [31:0] KEY1      = 32'h95A4_F1E0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              fwd_wr_en,
  output logic              fwd_rd_en,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_wdata,
  output logic              locked,
  output logic              key_pending,
  output logic [DATA_W-1:0] demo_q
);

  localparam logic [ADDR_W-1:0] A_K0   = ADDR_W'(KICK0_OFS);
  localparam logic [ADDR_W-1:0] A_K1   = ADDR_W'(KICK1_OFS);
  localparam logic [ADDR_W-1:0] A_DEMO = ADDR_W'(DEMO_OFS);
  localparam logic [DATA_W-1:0] K0     = DATA_W'(KEY0);
  localparam logic [DATA_W-1:0] K1     = DATA_W'(KEY1);

  logic hit_k0, hit_k1, good_k0, good_k1;

  assign hit_k0  = wr_en && (addr == A_K0);
  assign hit_k1  = wr_en && (addr == A_K1);
  assign good_k0 = hit_k0 && (wdata == K0);
  assign good_k1 = hit_k1 && (wdata == K1) && key_pending;

  assign fwd_wr_en = wr_en && !hit_k0 && !hit_k1 && !locked;
  assign fwd_rd_en = rd_en;
  assign fwd_addr  = addr;
  assign fwd_wdata = wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked      <= 1'b1;
      key_pending <= 1'b0;
    end else if (wr_en) begin
      key_pending <= good_k0;
      if (good_k1)
        locked <= 1'b0;
      else if (hit_k0 || hit_k1)
        locked <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      demo_q <= '0;
    else if (fwd_wr_en && addr == A_DEMO)
      demo_q <= wdata;
  end

  assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(demo_q));

  assert_unlock_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(wr_en && addr == A_K1 && wdata == K1 && key_pending));

  assert_pending_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_pending) |-> $past(wr_en && addr == A_K0 && wdata == K0));

  assert_k0_relock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_K0) |=> locked);

  assert_bad_k1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_K1 && wdata != K1) |=> (locked && !key_pending));

  assert_kick_hidden_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_K0 || addr == A_K1)) |-> !fwd_wr_en);

  assert_pend_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    key_pending |-> locked);

  assert_read_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && locked) |-> fwd_rd_en);

endmodule

// File: tb/kick_wp_gate_bench.sv
`timescale 1ns/1ps
module kick_wp_gate_bench;
  localparam logic [7:0]  K0A = 8'h6C, K1A = 8'h70, DEMO = 8'h00;
  localparam logic [31:0] KEY0 = 32'h83E7_0B13, KEY1 = 32'h95A4_F1E0;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic fwd_wr_en, fwd_rd_en, locked, key_pending;
  logic [7:0]  fwd_addr;
  logic [31:0] fwd_wdata, demo_q;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  kick_wp_gate u_kick_wp_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .fwd_wr_en(fwd_wr_en), .fwd_rd_en(fwd_rd_en),
    .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata), .locked(locked),
    .key_pending(key_pending), .demo_q(demo_q));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic fwd);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    #1 fwd = fwd_wr_en;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic unlock();
    logic f;
    wr(K0A, KEY0, f);
    wr(K1A, KEY1, f);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 locked", 32'(locked), 1);
    chk("R1 pending", 32'(key_pending), 0);
    chk("R1 demo", demo_q, 0);
  endtask

  task automatic t_locked_write();
    logic f;
    wr(DEMO, 32'hAAAA_5555, f);
    chk("R3 fwd_wr_en", 32'(f), 0);
    chk("R3 demo", demo_q, 0);
  endtask

  task automatic t_unlock();
    logic f;
    wr(K0A, KEY0, f);
    chk("R7 key0 hidden", 32'(f), 0);
    chk("R4 pending set", 32'(key_pending), 1);
    chk("R5 still locked", 32'(locked), 1);
    wr(K1A, KEY1, f);
    chk("R7 key1 hidden", 32'(f), 0);
    chk("R2 unlocked", 32'(locked), 0);
    chk("R2 pending clear", 32'(key_pending), 0);
  endtask

  task automatic t_open_write();
    logic f;
    wr(DEMO, 32'h1234_5678, f);
    chk("R8 fwd_wr_en", 32'(f), 1);
    chk("R8 demo", demo_q, 32'h1234_5678);
    wr(8'h20, 32'hDEAD_BEEF, f);
    chk("R8 other addr fwd", 32'(f), 1);
    chk("R8 demo kept", demo_q, 32'h1234_5678);
    wr(K1A, KEY1, f);
    chk("R7 kick hidden unlocked", 32'(f), 0);
  endtask

  task automatic t_reads();
    @(negedge clk);
    rd_en = 1;
    #1 chk("R9 read on", 32'(fwd_rd_en), 1);
    rd_en = 0;
    #1 chk("R9 read off", 32'(fwd_rd_en), 0);
  endtask

  task automatic t_relock_zero();
    logic f;
    wr(K0A, 32'h0, f);
    chk("R5 relock zero", 32'(locked), 1);
    wr(DEMO, 32'h0BAD_0BAD, f);
    chk("R3 fwd after relock", 32'(f), 0);
    chk("R3 demo after relock", demo_q, 32'h1234_5678);
    t_reads();
  endtask

  task automatic t_wrong_second();
    logic f;
    wr(K0A, KEY0, f);
    wr(K1A, KEY1 ^ 32'h1, f);
    chk("R6 wrong key1 locked", 32'(locked), 1);
    chk("R6 wrong key1 pending", 32'(key_pending), 0);
    wr(K1A, KEY1, f);
    chk("R6 key1 without key0", 32'(locked), 1);
  endtask

  task automatic t_interleave();
    logic f;
    wr(K0A, KEY0, f);
    wr(8'h10, 32'h55, f);
    chk("R4 pending cleared", 32'(key_pending), 0);
    wr(K1A, KEY1, f);
    chk("R4 no unlock", 32'(locked), 1);
  endtask

  task automatic t_reversed();
    logic f;
    wr(K1A, KEY1, f);
    wr(K0A, KEY0, f);
    chk("R6 reversed locked", 32'(locked), 1);
    chk("R4 reversed pending", 32'(key_pending), 1);
    wr(K1A, KEY1, f);
    chk("R2 completes", 32'(locked), 0);
  endtask

  task automatic t_key0_unlocked();
    logic f;
    wr(K0A, KEY0, f);
    chk("R5 key0 relocks", 32'(locked), 1);
    chk("R5 key0 arms", 32'(key_pending), 1);
    wr(K0A, 32'hFFFF_FFFF, f);
    chk("R5 bad key0", 32'(key_pending), 0);
  endtask

  initial begin
    t_reset();
    t_locked_write();
    t_reads();
    t_unlock();
    t_open_write();
    t_reads();
    t_relock_zero();
    t_wrong_second();
    t_interleave();
    t_reversed();
    t_key0_unlocked();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule